// File: doc/BRIEF.md
# Port Output Current Fault Monitor

This block supervises the load current of one powered port. It takes digitized current samples, each marked by a valid strobe, together with a port-powered enable and a 1 ms tick. From these it decides whether the port has been overloaded for too long or whether the attached device has gone away. Either decision produces a single-cycle event pulse and a latched shutdown request. The request first stops the switching clock of the port's converter and then, a fixed number of cycles later, opens the output FET.

Overload timing is integrating, not resetting. Each millisecond tick spent above the overload limit adds a large step to an accumulator. Each tick spent at or below the limit removes one sixteenth of that step. Short bursts of excess current therefore build up toward a trip instead of being forgotten. A separate run-length counter watches for the current staying below a small floor, which means the device has been unplugged. The decisions about restarting after a shutdown belong to the surrounding control and are outside this block. Dropping the enable returns the monitor to its idle state.

Top module: `port_current_guard`

## Requirements
- R1: After reset, and while no event has occurred, `oc_fault`, `disc_event`, `clk_off` and `fet_off` are all low.
- R2: Samples are in units of 0.1 mA. A sample above 3400 marks the port as overloaded. Each tick while overloaded adds 16 to the overload accumulator, which saturates at 960. On the 60th such tick from an empty accumulator, `oc_fault` pulses high for exactly one cycle, starting in the cycle after that tick's clock edge. After 59 such ticks there is no pulse.
- R3: Each tick while not overloaded subtracts 1 from the accumulator, which saturates at 0. A sample of exactly 3400 counts as not overloaded.
- R4: A sample below 75 marks the port as light. If 351 consecutive ticks occur while the port is light, `disc_event` pulses high for one cycle. After 350 such ticks there is no pulse.
- R5: Any valid sample of 75 or more clears the light marking and restarts the disconnect count from zero.
- R6: `clk_off` rises in the same cycle as an event pulse. `fet_off` rises exactly 4 cycles later (parameter FET_LAG). Both stay high while `port_on` remains high.
- R7: While `port_on` is low, both timers are cleared, all outputs are low, and samples have no effect.
- R8: Once a shutdown is in progress, no further event pulse occurs until `port_on` has gone low.
- R9: The classification follows the most recent valid sample and is held between samples. A tick is judged by the sample accepted on an earlier clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_on | input | 1 | Port powered; low holds the monitor idle |
| tick_1ms | input | 1 | One-cycle pulse each millisecond |
| cur_valid | input | 1 | Strobe marking a new current sample |
| cur_sample | input | CUR_W | Output current in 0.1 mA units |
| oc_fault | output | 1 | One-cycle overcurrent fault event |
| disc_event | output | 1 | One-cycle device disconnect event |
| clk_off | output | 1 | Shutdown request: stop switching clock |
| fet_off | output | 1 | Shutdown request: open output FET |

## Verification
The assertions check the following on every cycle:
- each event is a single-cycle pulse;
- the two events never coincide;
- an event is always accompanied by the clock-off request;
- the FET request never rises before the clock request;
- nothing is requested while the port is off.

Only the directed scenarios can show the counting itself: the exact tick on which an overload or disconnect trips, the one-sixteenth leak, the saturation at zero, the run-length restart on a healthy sample, and the exact lag between the two shutdown steps.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef struct packed {
    logic over;
    logic light;
  } cur_class_t;
endpackage

// File: rtl/pcg_classifier.sv
module pcg_classifier #(
  parameter int CUR_W      = 12,
  parameter int OC_LIMIT   = 3400,
  parameter int DISC_LIMIT = 75
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                cur_valid,
  input  logic [CUR_W-1:0]    cur_sample,
  output pcg_pkg::cur_class_t cls
);
  localparam logic [CUR_W-1:0] OC_L   = CUR_W'(OC_LIMIT);
  localparam logic [CUR_W-1:0] DISC_L = CUR_W'(DISC_LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cls <= '0;
    end else if (cur_valid) begin
      cls.over  <= (cur_sample > OC_L);
      cls.light <= (cur_sample < DISC_L);
    end
  end
endmodule

// File: rtl/pcg_leaky_timer.sv
module pcg_leaky_timer #(
  parameter int UP_STEP = 16,
  parameter int DN_STEP = 1,
  parameter int TRIP    = 960
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic over,
  output logic trip
);
  localparam int AW = $clog2(TRIP + 1);
  localparam logic [AW-1:0] TRIP_V = AW'(TRIP);
  localparam logic [AW-1:0] UP_V   = AW'(UP_STEP);
  localparam logic [AW-1:0] DN_V   = AW'(DN_STEP);

  logic [AW-1:0] acc_q;

  always_comb begin
    trip = run && tick && over && (acc_q >= TRIP_V - UP_V);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc_q <= '0;
    end else if (tick) begin
      if (over) begin
        acc_q <= trip ? TRIP_V : acc_q + UP_V;
      end else begin
        acc_q <= (acc_q >= DN_V) ? acc_q - DN_V : '0;
      end
    end
  end
endmodule

// File: rtl/pcg_disc_timer.sv
module pcg_disc_timer #(
  parameter int DISC_MS = 350
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic light,
  output logic gone
);
  localparam int CW = $clog2(DISC_MS + 1);
  localparam logic [CW-1:0] LIM = CW'(DISC_MS);

  logic [CW-1:0] cnt_q;

  always_comb begin
    gone = run && tick && light && (cnt_q == LIM);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || !light) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcg_shutdown_seq.sv
module pcg_shutdown_seq #(
  parameter int FET_LAG = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic port_on,
  input  logic start,
  output logic clk_off,
  output logic fet_off
);
  localparam int LW = $clog2(FET_LAG + 1);
  localparam logic [LW-1:0] LAST = LW'(FET_LAG - 1);

  logic [LW-1:0] lag_q;

  always_ff @(posedge clk) begin
    if (rst || !port_on) begin
      clk_off <= 1'b0;
      fet_off <= 1'b0;
      lag_q   <= '0;
    end else if (start && !clk_off) begin
      clk_off <= 1'b1;
      lag_q   <= '0;
    end else if (clk_off && !fet_off) begin
      lag_q <= lag_q + 1'b1;
      if (lag_q == LAST) fet_off <= 1'b1;
    end
  end
endmodule

// File: rtl/port_current_guard.sv
module port_current_guard #(
  parameter int CUR_W      = 12,
  parameter int OC_LIMIT   = 3400,
  parameter int DISC_LIMIT = 75,
  parameter int UP_STEP    = 16,
  parameter int DN_STEP    = 1,
  parameter int TRIP       = 960,
  parameter int DISC_MS    = 350,
  parameter int FET_LAG    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_on,
  input  logic             tick_1ms,
  input  logic             cur_valid,
  input  logic [CUR_W-1:0] cur_sample,
  output logic             oc_fault,
  output logic             disc_event,
  output logic             clk_off,
  output logic             fet_off
);
  pcg_pkg::cur_class_t cls;
  logic run, trip, gone;

  // timers only advance while powered and not already shutting down (R7, R8)
  always_comb run = port_on && !clk_off;

  pcg_classifier #(.CUR_W(CUR_W), .OC_LIMIT(OC_LIMIT), .DISC_LIMIT(DISC_LIMIT)) u_cls (
    .clk(clk), .rst(rst), .run(port_on), .cur_valid(cur_valid),
    .cur_sample(cur_sample), .cls(cls));

  pcg_leaky_timer #(.UP_STEP(UP_STEP), .DN_STEP(DN_STEP), .TRIP(TRIP)) u_oc (
    .clk(clk), .rst(rst), .run(run), .tick(tick_1ms), .over(cls.over), .trip(trip));

  pcg_disc_timer #(.DISC_MS(DISC_MS)) u_dc (
    .clk(clk), .rst(rst), .run(run), .tick(tick_1ms), .light(cls.light), .gone(gone));

  pcg_shutdown_seq #(.FET_LAG(FET_LAG)) u_sd (
    .clk(clk), .rst(rst), .port_on(port_on), .start(trip || gone),
    .clk_off(clk_off), .fet_off(fet_off));

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_fault   <= 1'b0;
      disc_event <= 1'b0;
    end else begin
      oc_fault   <= trip;
      disc_event <= gone && !trip;
    end
  end
endmodule

// File: rtl/port_current_guard_chk.sv
module port_current_guard_chk (
  input logic clk,
  input logic rst,
  input logic port_on,
  input logic oc_fault,
  input logic disc_event,
  input logic clk_off,
  input logic fet_off
);
  p_oc_single_r2: assert property (@(posedge clk) disable iff (rst)
    oc_fault |=> !oc_fault);
  p_disc_single_r4: assert property (@(posedge clk) disable iff (rst)
    disc_event |=> !disc_event);
  p_no_both_r8: assert property (@(posedge clk) disable iff (rst)
    !(oc_fault && disc_event));
  p_event_stops_clock_r6: assert property (@(posedge clk) disable iff (rst)
    (oc_fault || disc_event) |-> clk_off);
  p_fet_after_clock_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fet_off) |-> $past(clk_off));
  p_fet_needs_clock_r6: assert property (@(posedge clk) disable iff (rst)
    fet_off |-> clk_off);
  p_idle_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !port_on |=> (!clk_off && !fet_off && !oc_fault && !disc_event));
endmodule

bind port_current_guard port_current_guard_chk u_chk (
  .clk(clk), .rst(rst), .port_on(port_on), .oc_fault(oc_fault),
  .disc_event(disc_event), .clk_off(clk_off), .fet_off(fet_off));

// File: tb/sim_port_current_guard.sv
`timescale 1ns/1ps
module sim_port_current_guard;
  localparam int CUR_W = 12;
  localparam int FET_LAG = 4;

  logic clk = 1'b0;
  logic rst, port_on, tick_1ms, cur_valid;
  logic [CUR_W-1:0] cur_sample;
  logic oc_fault, disc_event, clk_off, fet_off;

  int total = 0;
  int bad = 0;
  int oc_n = 0;
  int dc_n = 0;

  always #2 clk = ~clk;

  port_current_guard #(.CUR_W(CUR_W), .FET_LAG(FET_LAG)) u0 (
    .clk(clk), .rst(rst), .port_on(port_on), .tick_1ms(tick_1ms),
    .cur_valid(cur_valid), .cur_sample(cur_sample), .oc_fault(oc_fault),
    .disc_event(disc_event), .clk_off(clk_off), .fet_off(fet_off));

  always @(posedge clk) begin
    if (oc_fault) oc_n <= oc_n + 1;
    if (disc_event) dc_n <= dc_n + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample(input int v);
    @(negedge clk);
    cur_valid = 1'b1; cur_sample = CUR_W'(v);
    @(negedge clk);
    cur_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1ms = 1'b1;
      @(negedge clk);
      tick_1ms = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic power_cycle();
    @(negedge clk); port_on = 1'b0;
    repeat (3) @(negedge clk);
    port_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 oc_fault", oc_fault, 0);
    check("R1 disc_event", disc_event, 0);
    check("R1 clk_off", clk_off, 0);
    check("R1 fet_off", fet_off, 0);
  endtask

  task automatic t_trip_exact();
    int base;
    power_cycle();
    base = oc_n;
    sample(3401);
    ticks(59);
    @(negedge clk);
    check("R2 no trip at 59", oc_n - base, 0);
    check("R2 no clk_off at 59", clk_off, 0);
    tick_1ms = 1'b1; @(negedge clk); tick_1ms = 1'b0;
    check("R2 pulse level", oc_fault, 1);
    check("R6 clk_off with pulse", clk_off, 1);
    check("R6 fet still on", fet_off, 0);
    @(negedge clk);
    check("R2 pulse one cycle", oc_fault, 0);
    repeat (FET_LAG - 2) @(negedge clk);
    check("R6 fet before lag", fet_off, 0);
    @(negedge clk);
    check("R6 fet after lag", fet_off, 1);
    ticks(80);
    check("R8 no second event", oc_n - base, 1);
    check("R6 clk_off held", clk_off, 1);
    check("R6 fet_off held", fet_off, 1);
  endtask

  task automatic t_leak();
    int base;
    power_cycle();
    check("R7 cleared clk_off", clk_off, 0);
    check("R7 cleared fet_off", fet_off, 0);
    base = oc_n;
    sample(3500); ticks(30);
    sample(3400); ticks(16);
    sample(3500); ticks(30);
    @(negedge clk);
    check("R3 leak 1/16 no trip", oc_n - base, 0);
    ticks(1);
    check("R3 leak 1/16 trips", oc_n - base, 1);
  endtask

  task automatic t_floor();
    int base;
    power_cycle();
    base = oc_n;
    sample(4000); ticks(10);
    sample(1000); ticks(200);
    sample(4000); ticks(59);
    check("R3 floor no trip", oc_n - base, 0);
    ticks(1);
    check("R3 floor trip", oc_n - base, 1);
  endtask

  task automatic t_at_limit();
    int base;
    power_cycle();
    base = oc_n;
    sample(3400); ticks(100);
    check("R3 at limit not over", oc_n - base, 0);
    check("R3 at limit clk_off", clk_off, 0);
  endtask

  task automatic t_disc();
    int base;
    power_cycle();
    base = dc_n;
    sample(50); ticks(350);
    check("R4 no disc at 350", dc_n - base, 0);
    ticks(1);
    check("R4 disc at 351", dc_n - base, 1);
    check("R4 disc clk_off", clk_off, 1);
  endtask

  task automatic t_disc_restart();
    int base;
    power_cycle();
    base = dc_n;
    sample(10); ticks(300);
    sample(75);
    sample(10); ticks(350);
    check("R5 restart no disc", dc_n - base, 0);
    ticks(1);
    check("R5 restart disc", dc_n - base, 1);
  endtask

  task automatic t_hold();
    int base;
    power_cycle();
    base = oc_n;
    sample(3600);
    @(negedge clk); cur_sample = CUR_W'(0);
    ticks(60);
    check("R9 held over sample", oc_n - base, 1);
  endtask

  task automatic t_off_ignored();
    int b1, b2;
    @(negedge clk); port_on = 1'b0;
    b1 = oc_n; b2 = dc_n;
    sample(4000); ticks(100);
    sample(5); ticks(400);
    check("R7 no oc while off", oc_n - b1, 0);
    check("R7 no disc while off", dc_n - b2, 0);
    check("R7 clk_off low while off", clk_off, 0);
    port_on = 1'b1;
    ticks(100);
    check("R7 sample ignored while off", oc_n - b1 + dc_n - b2, 0);
  endtask

  initial begin
    rst = 1'b1; port_on = 1'b0; tick_1ms = 1'b0; cur_valid = 1'b0;
    cur_sample = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_trip_exact();
    t_leak();
    t_floor();
    t_at_limit();
    t_disc();
    t_disc_restart();
    t_hold();
    t_off_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule